// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip: a sixteen-state controller stepped by the test mode select line, a 4-bit instruction register, a 1-bit bypass register, a 32-bit identification register and a boundary chain with a parameterised number of cells. Each instruction decides which register is placed between serial data in and serial data out. Two control outputs go to the functional core. One tells the output drivers to float. The other tells them to drive from the boundary hold latches instead of from the core logic.

The boundary chain has a parallel interface. The values the core would drive or sense are presented on `bnd_cap` and are loaded into the chain in Capture-DR. The hold latches appear on `bnd_hold`, and the core uses them when the drive-from-boundary control is set. All registers update on the rising edge of `tck`. Serial data out is retimed on the falling edge and comes with its own output-enable signal. A synchronous active-low reset and five consecutive high samples of TMS each bring the controller back to Test-Logic-Reset.

Top module: `scan_port`

## Requirements
- R1: The controller follows the standard sixteen-state test-port graph. TMS is sampled on each rising `tck` edge, and both the Pause-DR loop and the Exit2 return to Shift-DR are supported.
- R2: While `test_rst_n` is low at a rising edge, the controller enters Test-Logic-Reset and the instruction register takes the identification opcode 0010. Both control outputs are therefore low.
- R3: In Capture-IR the instruction shift stage loads 1101. In Shift-IR it shifts right, TDI enters at bit 3 and bit 0 appears on `tdo`, so the bits come out in the order 1,0,1,1.
- R4: The instruction becomes active at the rising edge that leaves Update-IR. The opcodes are 0000 drive-from-boundary test, 0001 sample/preload, 0010 identification, 0011 float outputs, 1000 clamp, 1101 validate and 1111 bypass.
- R5: Under opcode 0010, Capture-DR loads the identification word, least significant bit first out. The word has revision in bits 31:28, device code in bits 27:12, manufacturer code in bits 11:1, and bit 0 = 1.
- R6: Opcodes 0011, 1000, 1101, 1111 and every opcode not listed in R4 select the bypass bit. It captures 0, so in Shift-DR `tdo` repeats TDI one cycle late.
- R7: Opcodes 0000 and 0001 select the boundary chain. Capture-DR loads `bnd_cap`, bit 0 is shifted out first and TDI enters at the top cell. `bnd_hold` takes the chain contents at the edge that leaves Update-DR and does not change at any other time.
- R8: `pin_hiz` is high exactly while opcode 0011 is active. `pin_drive_bnd` is high exactly while opcode 0000 or 1000 is active.
- R9: `tdo_en` is high only in the half-cycle after a falling edge at which the controller was in Shift-DR or Shift-IR. `tdo` changes only on falling edges.
- R10: Five consecutive rising edges with TMS high bring the controller to Test-Logic-Reset from any state, and the instruction register returns to 0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| test_rst_n | input | 1 | Synchronous active-low reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| bnd_cap | input | BSR_LEN | Parallel values loaded into the boundary chain in Capture-DR |
| tdo | output | 1 | Serial data out, retimed on the falling edge |
| tdo_en | output | 1 | Output enable for `tdo` |
| bnd_hold | output | BSR_LEN | Boundary hold latches |
| pin_hiz | output | 1 | Float all functional outputs |
| pin_drive_bnd | output | 1 | Drive functional outputs from `bnd_hold` |

## Verification
The controller state, the shift stages, the instruction and `bnd_hold` all change at the rising edge that follows the stimulus cycle. The control outputs therefore change at the same edge as the instruction, the one that leaves Update-IR. `tdo` and `tdo_en` come half a cycle later, at the next falling edge. The bench drives inputs 1 ns after each falling edge and compares every output with a behavioural model 1 ns before the next rising edge. At that point the model has taken exactly the same number of rising edges as the design, and the falling-edge retiming has already happened.

// File: rtl/scan_port_pkg.sv
// Shared types for the test access port: controller states, opcodes
// and the decoded per-instruction control word.
package scan_port_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAUSE_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAUSE_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    localparam int OPW = 4;

    localparam logic [OPW-1:0] OP_EXTEST = 4'b0000;
    localparam logic [OPW-1:0] OP_SAMPLE = 4'b0001;
    localparam logic [OPW-1:0] OP_IDENT  = 4'b0010;
    localparam logic [OPW-1:0] OP_HIZ    = 4'b0011;
    localparam logic [OPW-1:0] OP_CLAMP  = 4'b1000;
    localparam logic [OPW-1:0] OP_VALID  = 4'b1101;
    localparam logic [OPW-1:0] OP_BYP    = 4'b1111;

    typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BND} dr_path_t;

    typedef struct packed {
        dr_path_t path;
        logic     hiz;
        logic     drive_bnd;
    } op_ctl_t;

endpackage

// File: rtl/scan_port_fsm.sv
// Sixteen-state test-port controller.
// Assumes: TMS is sampled on the rising tck edge; reset is synchronous,
// active low. Exposes the current state and the next state so that the
// instruction register can return to its default when the controller
// enters Test-Logic-Reset.
module scan_port_fsm
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state,
    output tap_state_t nxt
);

    // Next-state function of the standard controller graph.
    always_comb begin
        unique case (state)
            TS_RESET:    nxt = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:     nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR:   nxt = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR:   nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:    nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR:   nxt = tms ? TS_UPD_DR : TS_PAUSE_DR;
            TS_PAUSE_DR: nxt = tms ? TS_EX2_DR : TS_PAUSE_DR;
            TS_EX2_DR:   nxt = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR:   nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR:   nxt = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR:   nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:    nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR:   nxt = tms ? TS_UPD_IR : TS_PAUSE_IR;
            TS_PAUSE_IR: nxt = tms ? TS_EX2_IR : TS_PAUSE_IR;
            TS_EX2_IR:   nxt = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR:   nxt = tms ? TS_SEL_DR : TS_IDLE;
            default:     nxt = TS_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= TS_RESET;
        else        state <= nxt;
    end

    // R10: five TMS-high samples always end in Test-Logic-Reset.
    a_r10_five_ones: assert property (@(posedge tck) disable iff (!rst_n)
        (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> state == TS_RESET);

    // R1: Capture-IR with TMS low moves into Shift-IR.
    a_r1_cap_to_shift: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_CAP_IR && !tms) |=> state == TS_SH_IR);

endmodule

// File: rtl/scan_port_ir.sv
// Instruction register: a shift stage that captures the fixed pattern,
// an active instruction register loaded in Update-IR, and the opcode decode.
// Assumes: all state changes happen on the rising tck edge; reserved opcodes
// decode like bypass.
module scan_port_ir
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tdi,
    input  tap_state_t state,
    input  tap_state_t nxt,
    output logic       ir_lsb,
    output op_ctl_t    ctl
);

    logic [OPW-1:0] ir_sh;
    logic [OPW-1:0] ir_act;

    // Shift stage: capture the fixed pattern, then shift right from TDI.
    always_ff @(posedge tck) begin
        if (!rst_n)                 ir_sh <= '0;
        else if (state == TS_CAP_IR) ir_sh <= OP_VALID;
        else if (state == TS_SH_IR)  ir_sh <= {tdi, ir_sh[OPW-1:1]};
    end

    // Active instruction: default on reset or on entry to Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!rst_n || nxt == TS_RESET) ir_act <= OP_IDENT;
        else if (state == TS_UPD_IR)   ir_act <= ir_sh;
    end

    // Opcode decode into register path and core control bits.
    always_comb begin
        ctl = '{path: PATH_BYP, hiz: 1'b0, drive_bnd: 1'b0};
        case (ir_act)
            OP_EXTEST: ctl = '{path: PATH_BND, hiz: 1'b0, drive_bnd: 1'b1};
            OP_SAMPLE: ctl = '{path: PATH_BND, hiz: 1'b0, drive_bnd: 1'b0};
            OP_IDENT:  ctl = '{path: PATH_ID,  hiz: 1'b0, drive_bnd: 1'b0};
            OP_HIZ:    ctl = '{path: PATH_BYP, hiz: 1'b1, drive_bnd: 1'b0};
            OP_CLAMP:  ctl = '{path: PATH_BYP, hiz: 1'b0, drive_bnd: 1'b1};
            default:   ctl = '{path: PATH_BYP, hiz: 1'b0, drive_bnd: 1'b0};
        endcase
    end

    assign ir_lsb = ir_sh[0];

    // R3: Capture-IR leaves the fixed pattern in the shift stage.
    a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!rst_n)
        state == TS_CAP_IR |=> ir_sh == OP_VALID);

    // R2: while the controller sits in Test-Logic-Reset, identification is active.
    a_r2_reset_ident: assert property (@(posedge tck) disable iff (!rst_n)
        state == TS_RESET |-> ir_act == OP_IDENT);

endmodule

// File: rtl/scan_port_dr.sv
// Data registers: bypass bit, identification word and the boundary chain
// with its hold latches, plus the serial-out select by instruction path.
// Assumes: BSR_LEN >= 2; every action happens on the rising tck edge.
module scan_port_dr
    import scan_port_pkg::*;
#(
    parameter int               BSR_LEN = 8,
    parameter int               ID_W    = 32,
    parameter logic [ID_W-1:0]  ID_WORD = '1
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tdi,
    input  tap_state_t         state,
    input  dr_path_t           path,
    input  logic [BSR_LEN-1:0] bnd_cap,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] bnd_hold
);

    localparam int TOP = BSR_LEN - 1;

    logic              byp_q;
    logic [ID_W-1:0]   id_sh;
    logic [BSR_LEN-1:0] chain;

    logic cap_en, sh_en, upd_en;
    assign cap_en = (state == TS_CAP_DR);
    assign sh_en  = (state == TS_SH_DR);
    assign upd_en = (state == TS_UPD_DR);

    // Bypass bit: captures zero, shifts TDI.
    always_ff @(posedge tck) begin
        if (!rst_n)                           byp_q <= 1'b0;
        else if (path == PATH_BYP && cap_en)  byp_q <= 1'b0;
        else if (path == PATH_BYP && sh_en)   byp_q <= tdi;
    end

    // Identification register: captures the fixed word, shifts right.
    always_ff @(posedge tck) begin
        if (!rst_n)                          id_sh <= '0;
        else if (path == PATH_ID && cap_en)  id_sh <= ID_WORD;
        else if (path == PATH_ID && sh_en)   id_sh <= {tdi, id_sh[ID_W-1:1]};
    end

    // Boundary cells: one capture/shift stage and one hold latch per cell.
    for (genvar g = 0; g < BSR_LEN; g++) begin : g_cell
        logic shin;
        if (g == TOP) begin : g_top
            assign shin = tdi;
        end else begin : g_mid
            assign shin = chain[g+1];
        end

        // Capture/shift stage of one cell.
        always_ff @(posedge tck) begin
            if (!rst_n)                           chain[g] <= 1'b0;
            else if (path == PATH_BND && cap_en)  chain[g] <= bnd_cap[g];
            else if (path == PATH_BND && sh_en)   chain[g] <= shin;
        end

        // Hold latch of one cell, loaded in Update-DR.
        always_ff @(posedge tck) begin
            if (!rst_n)                           bnd_hold[g] <= 1'b0;
            else if (path == PATH_BND && upd_en)  bnd_hold[g] <= chain[g];
        end
    end

    // Serial-out select by instruction path.
    always_comb begin
        unique case (path)
            PATH_ID:  dr_lsb = id_sh[0];
            PATH_BND: dr_lsb = chain[0];
            default:  dr_lsb = byp_q;
        endcase
    end

    // R6: the bypass bit reads zero after Capture-DR.
    a_r6_bypass_zero: assert property (@(posedge tck) disable iff (!rst_n)
        (path == PATH_BYP && cap_en) |=> byp_q == 1'b0);

    // R7: hold latches change only at the Update-DR edge of a boundary instruction.
    a_r7_hold_stable: assert property (@(posedge tck) disable iff (!rst_n)
        !(path == PATH_BND && upd_en) |=> $stable(bnd_hold));

endmodule

// File: rtl/scan_port.sv
// Test access port top: controller, instruction register, data registers
// and the falling-edge serial output stage.
// Assumes: a single tck domain; test_rst_n is synchronous and active low;
// tdo_en is used by a pad driver outside the block.
module scan_port
    import scan_port_pkg::*;
#(
    parameter int          BSR_LEN = 8,
    parameter logic [3:0]  ID_REV  = 4'h3,
    parameter logic [15:0] ID_PART = 16'h5A3C,
    parameter logic [10:0] ID_MFR  = 11'h0B5
) (
    input  logic               tck,
    input  logic               test_rst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] bnd_cap,
    output logic               tdo,
    output logic               tdo_en,
    output logic [BSR_LEN-1:0] bnd_hold,
    output logic               pin_hiz,
    output logic               pin_drive_bnd
);

    localparam int          ID_W    = 32;
    localparam logic [ID_W-1:0] ID_WORD = {ID_REV, ID_PART, ID_MFR, 1'b1};

    tap_state_t state, nxt;
    op_ctl_t    ctl;
    logic       ir_lsb, dr_lsb;
    logic       in_shift;

    scan_port_fsm u_fsm (
        .tck   (tck),
        .rst_n (test_rst_n),
        .tms   (tms),
        .state (state),
        .nxt   (nxt)
    );

    scan_port_ir u_ir (
        .tck    (tck),
        .rst_n  (test_rst_n),
        .tdi    (tdi),
        .state  (state),
        .nxt    (nxt),
        .ir_lsb (ir_lsb),
        .ctl    (ctl)
    );

    scan_port_dr #(
        .BSR_LEN (BSR_LEN),
        .ID_W    (ID_W),
        .ID_WORD (ID_WORD)
    ) u_dr (
        .tck      (tck),
        .rst_n    (test_rst_n),
        .tdi      (tdi),
        .state    (state),
        .path     (ctl.path),
        .bnd_cap  (bnd_cap),
        .dr_lsb   (dr_lsb),
        .bnd_hold (bnd_hold)
    );

    assign in_shift = (state == TS_SH_DR) || (state == TS_SH_IR);

    // Serial output stage, retimed on the falling edge.
    always_ff @(negedge tck) begin
        if (!test_rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= (state == TS_SH_IR) ? ir_lsb : dr_lsb;
            tdo_en <= in_shift;
        end
    end

    assign pin_hiz       = ctl.hiz;
    assign pin_drive_bnd = ctl.drive_bnd;

    // R9: outside the shift states the output enable drops at the next falling edge.
    a_r9_tdo_quiet: assert property (@(negedge tck) disable iff (!test_rst_n)
        !in_shift |=> !tdo_en);

    // R8: the core is never asked to float and to drive at the same time.
    a_r8_ctl_exclusive: assert property (@(posedge tck) disable iff (!test_rst_n)
        !(pin_hiz && pin_drive_bnd));

endmodule

// File: tb/tb_scan_port.sv
module tb_scan_port;

    localparam int          L     = 8;
    localparam logic [3:0]  REV   = 4'h3;
    localparam logic [15:0] PART  = 16'h5A3C;
    localparam logic [10:0] MFR   = 11'h0B5;
    localparam logic [31:0] IDW   = {REV, PART, MFR, 1'b1};

    // model state codes (own numbering)
    localparam int X_TLR=15, X_IDL=12, X_SDR=7, X_CDR=6, X_HDR=2, X_E1D=1, X_PDR=3, X_E2D=0, X_UDR=5;
    localparam int X_SIR=4, X_CIR=14, X_HIR=10, X_E1I=9, X_PIR=11, X_E2I=8, X_UIR=13;

    logic tck = 1'b0;
    logic test_rst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [L-1:0] bnd_cap = '0;
    logic tdo, tdo_en, pin_hiz, pin_drive_bnd;
    logic [L-1:0] bnd_hold;

    int checks = 0;
    int failures = 0;
    bit cmp_on = 0;

    // reference model
    int ms = X_TLR;
    int mir = 2;
    bit irq[$];
    bit dq[$];
    logic [L-1:0] mhold = '0;

    scan_port #(.BSR_LEN(L), .ID_REV(REV), .ID_PART(PART), .ID_MFR(MFR)) dut (
        .tck(tck), .test_rst_n(test_rst_n), .tms(tms), .tdi(tdi), .bnd_cap(bnd_cap),
        .tdo(tdo), .tdo_en(tdo_en), .bnd_hold(bnd_hold),
        .pin_hiz(pin_hiz), .pin_drive_bnd(pin_drive_bnd));

    always #10 tck = ~tck;

    function automatic int m_next(int s, bit m);
        case (s)
            X_TLR: return m ? X_TLR : X_IDL;
            X_IDL: return m ? X_SDR : X_IDL;
            X_SDR: return m ? X_SIR : X_CDR;
            X_CDR: return m ? X_E1D : X_HDR;
            X_HDR: return m ? X_E1D : X_HDR;
            X_E1D: return m ? X_UDR : X_PDR;
            X_PDR: return m ? X_E2D : X_PDR;
            X_E2D: return m ? X_UDR : X_HDR;
            X_UDR: return m ? X_SDR : X_IDL;
            X_SIR: return m ? X_TLR : X_CIR;
            X_CIR: return m ? X_E1I : X_HIR;
            X_HIR: return m ? X_E1I : X_HIR;
            X_E1I: return m ? X_UIR : X_PIR;
            X_PIR: return m ? X_E2I : X_PIR;
            X_E2I: return m ? X_UIR : X_HIR;
            default: return m ? X_SDR : X_IDL;
        endcase
    endfunction

    // 0 = boundary, 1 = identification, 2 = bypass
    function automatic int m_path(int op);
        if (op == 0 || op == 1) return 0;
        if (op == 2) return 1;
        return 2;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit en_exp;
        int p;
        en_exp = (ms == X_HDR || ms == X_HIR);
        check(tdo_en == en_exp, "R9 tdo_en", tdo_en, en_exp);
        if (en_exp) begin
            if (ms == X_HIR) check(tdo == irq[0], "R3 ir shift-out", tdo, irq[0]);
            else begin
                p = m_path(mir);
                if (p == 1)      check(tdo == dq[0], "R5 id shift-out", tdo, dq[0]);
                else if (p == 0) check(tdo == dq[0], "R7 boundary shift-out", tdo, dq[0]);
                else             check(tdo == dq[0], "R6 bypass shift-out", tdo, dq[0]);
            end
        end
        check(pin_hiz == (mir == 3), "R8 pin_hiz", pin_hiz, mir == 3);
        check(pin_drive_bnd == (mir == 0 || mir == 8), "R8 pin_drive_bnd",
              pin_drive_bnd, (mir == 0 || mir == 8));
        check(bnd_hold == mhold, "R7 bnd_hold", bnd_hold, mhold);
    endtask

    task automatic model_step(input bit m, input bit d);
        int p;
        if (!test_rst_n) begin
            ms = X_TLR; mir = 2; mhold = '0;
            irq.delete(); dq.delete();
            return;
        end
        p = m_path(mir);
        case (ms)
            X_CIR: irq = '{1'b1, 1'b0, 1'b1, 1'b1};
            X_HIR: begin void'(irq.pop_front()); irq.push_back(d); end
            X_UIR: mir = irq[0] + 2*irq[1] + 4*irq[2] + 8*irq[3];
            X_CDR: begin
                dq.delete();
                if (p == 1)      for (int i = 0; i < 32; i++) dq.push_back(IDW[i]);
                else if (p == 0) for (int i = 0; i < L; i++) dq.push_back(bnd_cap[i]);
                else             dq.push_back(1'b0);
            end
            X_HDR: begin void'(dq.pop_front()); dq.push_back(d); end
            X_UDR: if (p == 0) for (int i = 0; i < L; i++) mhold[i] = dq[i];
            default: ;
        endcase
        ms = m_next(ms, m);
        if (ms == X_TLR) mir = 2;
    endtask

    // one TCK cycle: inputs already at negedge+1, compare at posedge-1
    task automatic tick(input bit m, input bit d);
        tms = m; tdi = d;
        #8;
        if (cmp_on) compare_all();
        @(posedge tck);
        model_step(m, d);
        @(negedge tck); #1;
    endtask

    task automatic load_ir(input logic [3:0] op);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 4; i++) tick(i == 3, op[i]);
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] bits);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) tick(i == n - 1, bits[i]);
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge tck); #1;
        tick(1, 0);
        cmp_on = 1;
        tick(0, 1); tick(1, 0);
        // R2: reset state
        check(tdo_en == 0, "R2 tdo_en after reset", tdo_en, 0);
        check(pin_hiz == 0 && pin_drive_bnd == 0, "R2 controls after reset",
              {pin_hiz, pin_drive_bnd}, 0);
        test_rst_n = 1'b1;
        tick(0, 0);

        // R5: identification word after reset
        scan_dr(32, 64'hA5A5_0F0F);
        // R5 + R1: identification with a pause loop
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 10; i++) tick(0, i[0]);
        tick(1, 1); tick(0, 0); tick(0, 0); tick(1, 0);
        // R1: back in Shift-DR via Exit2
        tick(0, 1);
        check(tdo_en == 1, "R1 shift-DR after exit2", tdo_en, 1);
        for (int i = 0; i < 21; i++) tick(i == 20, 1'b1);
        tick(1, 0); tick(0, 0);

        // R6: bypass
        load_ir(4'b1111);
        scan_dr(12, 64'h0000_0B6D);

        // R7: sample/preload
        bnd_cap = 8'hC3;
        load_ir(4'b0001);
        scan_dr(L, 64'h5A);
        check(bnd_hold == 8'h5A, "R7 hold after sample", bnd_hold, 8'h5A);
        check(pin_drive_bnd == 0, "R8 sample does not drive", pin_drive_bnd, 0);

        // R4/R8: boundary-driven test
        bnd_cap = 8'h3E;
        load_ir(4'b0000);
        check(pin_drive_bnd == 1, "R4 opcode 0000 drive", pin_drive_bnd, 1);
        scan_dr(L, 64'h81);
        check(bnd_hold == 8'h81, "R7 hold after extest", bnd_hold, 8'h81);

        // R4/R8: float outputs, bypass path
        load_ir(4'b0011);
        check(pin_hiz == 1, "R4 opcode 0011 float", pin_hiz, 1);
        scan_dr(6, 64'h2D);
        check(bnd_hold == 8'h81, "R7 hold untouched under bypass", bnd_hold, 8'h81);

        // clamp
        load_ir(4'b1000);
        check(pin_drive_bnd == 1 && pin_hiz == 0, "R8 clamp controls",
              {pin_hiz, pin_drive_bnd}, 1);
        scan_dr(5, 64'h13);

        // R6: reserved and validate behave as bypass
        load_ir(4'b0101);
        check(pin_hiz == 0 && pin_drive_bnd == 0, "R6 reserved controls",
              {pin_hiz, pin_drive_bnd}, 0);
        scan_dr(7, 64'h55);
        load_ir(4'b1101);
        scan_dr(4, 64'h9);

        // R10: five TMS-high cycles from Shift-DR
        load_ir(4'b0011);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 5; i++) tick(1, 0);
        check(pin_hiz == 0, "R10 instruction back to identification", pin_hiz, 0);
        check(tdo_en == 0, "R10 output disabled", tdo_en, 0);
        tick(0, 0);
        scan_dr(32, 64'h0);

        // R2: synchronous reset in the middle of a shift
        load_ir(4'b0000);
        tick(1, 0); tick(0, 0); tick(0, 0);
        test_rst_n = 1'b0;
        tick(0, 0); tick(0, 0);
        check(pin_drive_bnd == 0, "R2 reset clears instruction", pin_drive_bnd, 0);
        check(bnd_hold == 0, "R2 reset clears hold", bnd_hold, 0);
        test_rst_n = 1'b1;
        tick(0, 0);
        scan_dr(32, 64'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule